// File: doc/BRIEF.md
# End-of-Interrupt Deactivation Unit

This block takes a guest end-of-interrupt write, made of an interrupt ID and a group, and closes out the matching virtual interrupt. On every write it first asks the active-priority tracker to drop the highest active priority, and the tracker returns the dropped level in the same cycle. The block then looks through the used part of the list-register bank for an active entry that carries the written ID. If that entry agrees with the request in both group and preemption level, the unit clears the entry's active bit and emits a write-back. When the entry is linked to a physical interrupt, the unit also forwards a deactivate request with that entry's physical ID.

No deactivation is attempted for IDs in the message-based range or when the split EOI mode flag is set. An EOI that finds no active entry increments a wrapping 5-bit counter. A separate combinational output tells the hypervisor whether a maintenance interrupt should be expected for the current live entries.

List-register entry layout, 40 bits: virtual ID [15:0], physical ID [25:16], EOI-notify [26], priority [34:27], group [35], hardware-link [36], pending [37], active [38], bit 39 reserved.

Top module: `eoi_deact_unit`

## Requirements
- R1: `drop_req` is high in every cycle in which `eoi_valid` is high, whatever the outcome of that EOI.
- R2: An EOI whose ID is 8192 or above produces no write-back, no physical deactivate and no change of `eoi_count`.
- R3: An EOI made with `eoi_mode` high produces no write-back, no physical deactivate and no change of `eoi_count`.
- R4: The matching entry is the lowest index below `lr_used` whose virtual ID equals `eoi_id` and whose active bit is 1. Entries at or above `lr_used`, and entries whose active bit is 0, are never chosen.
- R5: When no entry matches, `eoi_count` rises by one in the cycle after the EOI, wrapping from 31 to 0. No write-back is made in that case.
- R6: A matching entry is left alone, with no write-back, if its group bit differs from `eoi_grp` or if its preemption level differs from `drop_prio`.
- R7: Otherwise, in the cycle after the EOI, `wb_valid` pulses with `wb_idx` set to the entry index and `wb_data` equal to the entry with only bit 38 cleared.
- R8: If the written-back entry has bit 36 set, `pdeact_valid` pulses in that same cycle and `pdeact_id` carries bits [25:16] of the entry. Otherwise `pdeact_valid` stays low.
- R9: The preemption level is the priority with its low `s` bits cleared. For group 0, `s = bp0 + 1`. For group 1, `s = bp1`, except that when `bp_common` is high, `s = min(bp0 + 1, 7)`.
- R10: `maint_expect` is high when `uie` is high, or when some entry flagged in `lr_live` has bit 26 set and bit 36 clear.
- R11: While reset is low, `wb_valid` and `pdeact_valid` are 0 and `eoi_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi_valid | input | 1 | EOI write strobe |
| eoi_id | input | 16 | Interrupt ID written |
| eoi_grp | input | 1 | Group of the EOI register used |
| eoi_mode | input | 1 | Split EOI mode: drop only |
| bp0 | input | 3 | Group 0 binary point |
| bp1 | input | 3 | Group 1 binary point |
| bp_common | input | 1 | Group 1 uses group 0 binary point |
| drop_prio | input | 8 | Priority dropped by the tracker this cycle |
| lr_bank | input | NLR*40 | List-register bank, entry 0 in the low bits |
| lr_used | input | $clog2(NLR+1) | Number of entries in use |
| lr_live | input | NLR | Entries loaded for the running guest |
| uie | input | 1 | Underflow interrupt enable |
| drop_req | output | 1 | Priority-drop request to the tracker |
| wb_valid | output | 1 | Entry write-back strobe |
| wb_idx | output | $clog2(NLR) | Entry index written back |
| wb_data | output | 40 | Entry value written back |
| eoi_count | output | 5 | Unmatched-EOI counter |
| pdeact_valid | output | 1 | Physical deactivate strobe |
| pdeact_id | output | 10 | Physical ID to deactivate |
| maint_expect | output | 1 | A maintenance interrupt is expected |

## Verification
The hardest case to reach is the one where an entry matches on ID and active state but the preemption check fails only because the binary point changes which priority bits count. This includes the group 1 path under a shared binary point that saturates at 7. The stimulus table holds one fixed bank and sweeps the binary point inputs and the returned drop priority, so that a single entry both deactivates and is left alone depending only on those inputs. The bank also holds an inactive entry with a duplicate ID ahead of the real match, and an active entry just past the used count, to exercise the search limits.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
  localparam int ENTRY_W  = 40;
  localparam int VID_LSB  = 0;
  localparam int VID_W    = 16;
  localparam int PID_LSB  = 16;
  localparam int PID_W    = 10;
  localparam int NTF_BIT  = 26;
  localparam int PRI_LSB  = 27;
  localparam int PRI_W    = 8;
  localparam int GRP_BIT  = 35;
  localparam int HW_BIT   = 36;
  localparam int PEND_BIT = 37;
  localparam int ACT_BIT  = 38;
  localparam int BP_W     = 3;
endpackage

// File: rtl/eoi_preempt.sv
module eoi_preempt
  import eoi_pkg::*;
(
  input  logic [PRI_W-1:0] prio,
  input  logic             grp,
  input  logic [BP_W-1:0]  bp0,
  input  logic [BP_W-1:0]  bp1,
  input  logic             bp_common,
  output logic [PRI_W-1:0] level
);
  logic [BP_W:0] shift;

  always_comb begin
    if (!grp)
      shift = {1'b0, bp0} + 1'b1;
    else if (bp_common)
      shift = (bp0 == {BP_W{1'b1}}) ? {1'b0, bp0} : {1'b0, bp0} + 1'b1;
    else
      shift = {1'b0, bp1};
    level = prio & ({PRI_W{1'b1}} << shift);
  end
endmodule

// File: rtl/eoi_match.sv
module eoi_match
  import eoi_pkg::*;
#(
  parameter int NLR = 4,
  localparam int IDX_W = (NLR > 1) ? $clog2(NLR) : 1,
  localparam int CNT_W = $clog2(NLR + 1)
) (
  input  logic [NLR*ENTRY_W-1:0] bank,
  input  logic [CNT_W-1:0]       used,
  input  logic [VID_W-1:0]       id,
  output logic                   found,
  output logic [IDX_W-1:0]       idx,
  output logic [ENTRY_W-1:0]     entry
);
  logic [NLR-1:0] hit;

  for (genvar g = 0; g < NLR; g++) begin : g_hit
    localparam logic [CNT_W-1:0] GI = CNT_W'(g);
    assign hit[g] = (GI < used)
                 && (bank[g*ENTRY_W+VID_LSB +: VID_W] == id)
                 && bank[g*ENTRY_W+ACT_BIT];
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NLR - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    entry = bank[idx*ENTRY_W +: ENTRY_W];
  end
endmodule

// File: rtl/eoi_deact_unit.sv
module eoi_deact_unit
  import eoi_pkg::*;
#(
  parameter int NLR      = 4,
  parameter int LPI_BASE = 8192,
  parameter int CNT_FW   = 5,
  localparam int IDX_W = (NLR > 1) ? $clog2(NLR) : 1,
  localparam int CNT_W = $clog2(NLR + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid,
  input  logic [VID_W-1:0]       eoi_id,
  input  logic                   eoi_grp,
  input  logic                   eoi_mode,
  input  logic [BP_W-1:0]        bp0,
  input  logic [BP_W-1:0]        bp1,
  input  logic                   bp_common,
  input  logic [PRI_W-1:0]       drop_prio,
  input  logic [NLR*ENTRY_W-1:0] lr_bank,
  input  logic [CNT_W-1:0]       lr_used,
  input  logic [NLR-1:0]         lr_live,
  input  logic                   uie,
  output logic                   drop_req,
  output logic                   wb_valid,
  output logic [IDX_W-1:0]       wb_idx,
  output logic [ENTRY_W-1:0]     wb_data,
  output logic [CNT_FW-1:0]      eoi_count,
  output logic                   pdeact_valid,
  output logic [PID_W-1:0]       pdeact_id,
  output logic                   maint_expect
);
  logic               found;
  logic [IDX_W-1:0]   hit_idx;
  logic [ENTRY_W-1:0] hit_entry;
  logic [PRI_W-1:0]   hit_level;
  logic               skip_deact;
  logic               wb_en_d, pd_en_d, inc_d;
  logic [ENTRY_W-1:0] wb_data_d;
  logic [NLR-1:0]     notify_live;

  eoi_match #(.NLR(NLR)) u_match (
    .bank(lr_bank), .used(lr_used), .id(eoi_id),
    .found(found), .idx(hit_idx), .entry(hit_entry)
  );

  eoi_preempt u_pre (
    .prio(hit_entry[PRI_LSB +: PRI_W]), .grp(eoi_grp),
    .bp0(bp0), .bp1(bp1), .bp_common(bp_common), .level(hit_level)
  );

  assign drop_req = eoi_valid;

  always_comb begin
    skip_deact = eoi_mode || (32'(eoi_id) >= LPI_BASE);
    inc_d      = eoi_valid && !skip_deact && !found;
    wb_en_d    = eoi_valid && !skip_deact && found
              && (hit_entry[GRP_BIT] == eoi_grp)
              && (hit_level == drop_prio);
    pd_en_d    = wb_en_d && hit_entry[HW_BIT];
    wb_data_d  = hit_entry;
    wb_data_d[ACT_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid     <= 1'b0;
      pdeact_valid <= 1'b0;
      eoi_count    <= '0;
    end else begin
      wb_valid     <= wb_en_d;
      pdeact_valid <= pd_en_d;
      if (inc_d) eoi_count <= eoi_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_idx    <= '0;
      wb_data   <= '0;
      pdeact_id <= '0;
    end else if (wb_en_d) begin
      wb_idx    <= hit_idx;
      wb_data   <= wb_data_d;
      pdeact_id <= hit_entry[PID_LSB +: PID_W];
    end
  end

  for (genvar g = 0; g < NLR; g++) begin : g_mi
    assign notify_live[g] = lr_live[g]
                         && lr_bank[g*ENTRY_W+NTF_BIT]
                         && !lr_bank[g*ENTRY_W+HW_BIT];
  end
  assign maint_expect = uie || (|notify_live);
endmodule

// File: rtl/eoi_deact_chk.sv
module eoi_deact_chk
  import eoi_pkg::*;
#(
  parameter int NLR      = 4,
  parameter int LPI_BASE = 8192,
  parameter int CNT_FW   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eoi_valid,
  input logic [VID_W-1:0]   eoi_id,
  input logic               eoi_mode,
  input logic               drop_req,
  input logic               wb_valid,
  input logic [ENTRY_W-1:0] wb_data,
  input logic [CNT_FW-1:0]  eoi_count,
  input logic               pdeact_valid
);
  assert_wb_after_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(drop_req));

  assert_lpi_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && 32'(eoi_id) >= LPI_BASE) |=> (!wb_valid && !pdeact_valid && $stable(eoi_count)));

  assert_mode_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_mode) |=> (!wb_valid && !pdeact_valid && $stable(eoi_count)));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eoi_count) |-> (eoi_count == $past(eoi_count) + 1'b1) && !wb_valid);

  assert_wb_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !wb_data[ACT_BIT]);

  assert_pd_needs_hw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pdeact_valid |-> (wb_valid && wb_data[HW_BIT]));
endmodule

bind eoi_deact_unit eoi_deact_chk #(.NLR(NLR), .LPI_BASE(LPI_BASE), .CNT_FW(CNT_FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
  .eoi_mode(eoi_mode), .drop_req(drop_req), .wb_valid(wb_valid),
  .wb_data(wb_data), .eoi_count(eoi_count), .pdeact_valid(pdeact_valid)
);

// File: tb/test_eoi_deact_unit.sv
module test_eoi_deact_unit;
  import eoi_pkg::*;
  localparam int NLR = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic eoi_valid, eoi_grp, eoi_mode, bp_common, uie;
  logic [15:0] eoi_id;
  logic [2:0] bp0, bp1;
  logic [7:0] drop_prio;
  logic [NLR*ENTRY_W-1:0] lr_bank;
  logic [2:0] lr_used;
  logic [NLR-1:0] lr_live;
  logic drop_req, wb_valid, pdeact_valid, maint_expect;
  logic [1:0] wb_idx;
  logic [ENTRY_W-1:0] wb_data;
  logic [4:0] eoi_count;
  logic [9:0] pdeact_id;

  int total = 0, failed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eoi_deact_unit i_eoi_deact_unit (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
    .eoi_grp(eoi_grp), .eoi_mode(eoi_mode), .bp0(bp0), .bp1(bp1),
    .bp_common(bp_common), .drop_prio(drop_prio), .lr_bank(lr_bank),
    .lr_used(lr_used), .lr_live(lr_live), .uie(uie), .drop_req(drop_req),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .eoi_count(eoi_count), .pdeact_valid(pdeact_valid),
    .pdeact_id(pdeact_id), .maint_expect(maint_expect)
  );

  function automatic logic [ENTRY_W-1:0] mk(input logic [15:0] vid, input logic [9:0] pid,
      input logic ntf, input logic [7:0] pri, input logic grp, input logic hw, input logic act);
    logic [ENTRY_W-1:0] e;
    e = '0;
    e[15:0] = vid; e[25:16] = pid; e[26] = ntf; e[34:27] = pri;
    e[35] = grp; e[36] = hw; e[38] = act;
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {id16, grp, mode, bp0, bp1, common, drop8, exp_wb, exp_idx2, exp_pd, exp_inc}
  localparam logic [37:0] VEC [10] = '{
    {16'd5,    1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h40, 1'b1, 2'd0, 1'b0, 1'b0}, // R7 match
    {16'd5,    1'b0, 1'b0, 3'd2, 3'd3, 1'b0, 8'h40, 1'b0, 2'd0, 1'b0, 1'b0}, // R6 group
    {16'd5,    1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h48, 1'b0, 2'd0, 1'b0, 1'b0}, // R6 level
    {16'd7,    1'b0, 1'b0, 3'd2, 3'd3, 1'b0, 8'h80, 1'b1, 2'd2, 1'b1, 1'b0}, // R4 R8
    {16'd9,    1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h20, 1'b0, 2'd0, 1'b0, 1'b1}, // R4 R5
    {16'd8192, 1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h40, 1'b0, 2'd0, 1'b0, 1'b0}, // R2
    {16'd5,    1'b1, 1'b1, 3'd2, 3'd3, 1'b0, 8'h40, 1'b0, 2'd0, 1'b0, 1'b0}, // R3
    {16'd5,    1'b1, 1'b0, 3'd6, 3'd3, 1'b1, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0}, // R9 common
    {16'd7,    1'b0, 1'b0, 3'd6, 3'd3, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0}, // R9 grp0
    {16'd5,    1'b1, 1'b0, 3'd2, 3'd1, 1'b0, 8'h40, 1'b1, 2'd0, 1'b0, 1'b0}  // R9 bp1
  };

  logic [ENTRY_W-1:0] ent [NLR];

  task automatic do_eoi(input logic [15:0] id, input logic g, input logic m,
      input logic [2:0] b0, input logic [2:0] b1, input logic c, input logic [7:0] dp);
    @(negedge clk);
    eoi_id = id; eoi_grp = g; eoi_mode = m; bp0 = b0; bp1 = b1; bp_common = c;
    drop_prio = dp; eoi_valid = 1'b1;
    #1 chk("R1 drop_req", 64'(drop_req), 64'd1);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic load_bank;
    for (int i = 0; i < NLR; i++) lr_bank[i*ENTRY_W +: ENTRY_W] = ent[i];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [4:0] c0;
    rst_n = 1'b0; eoi_valid = 1'b0; eoi_id = '0; eoi_grp = 1'b0; eoi_mode = 1'b0;
    bp0 = '0; bp1 = '0; bp_common = 1'b0; drop_prio = '0; uie = 1'b0;
    lr_live = '0; lr_used = 3'd3;
    ent[0] = mk(16'd5, 10'h000, 1'b0, 8'h40, 1'b1, 1'b0, 1'b1);
    ent[1] = mk(16'd7, 10'h02A, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0);
    ent[2] = mk(16'd7, 10'h155, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1);
    ent[3] = mk(16'd9, 10'h000, 1'b0, 8'h20, 1'b1, 1'b0, 1'b1);
    load_bank();
    repeat (3) @(negedge clk);
    chk("R11 wb_valid in reset", 64'(wb_valid), 64'd0);
    chk("R11 pdeact in reset", 64'(pdeact_valid), 64'd0);
    chk("R11 count in reset", 64'(eoi_count), 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      logic [37:0] t;
      logic [ENTRY_W-1:0] exp_d;
      t = VEC[v];
      c0 = eoi_count;
      do_eoi(t[37:22], t[21], t[20], t[19:17], t[16:14], t[13], t[12:5]);
      chk($sformatf("R7 wb_valid vec%0d", v), 64'(wb_valid), 64'(t[4]));
      chk($sformatf("R8 pdeact vec%0d", v), 64'(pdeact_valid), 64'(t[1]));
      chk($sformatf("R5 count vec%0d", v), 64'(eoi_count), 64'(5'(c0 + 5'(t[0]))));
      if (t[4]) begin
        exp_d = ent[t[3:2]];
        exp_d[38] = 1'b0;
        chk($sformatf("R4 wb_idx vec%0d", v), 64'(wb_idx), 64'(t[3:2]));
        chk($sformatf("R7 wb_data vec%0d", v), 64'(wb_data), 64'(exp_d));
      end
      if (t[1]) chk($sformatf("R8 pdeact_id vec%0d", v), 64'(pdeact_id), 64'h155);
    end

    // R4: entry 3 becomes eligible once the used count covers it
    lr_used = 3'd4;
    c0 = eoi_count;
    do_eoi(16'd9, 1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h20);
    chk("R4 used=4 wb_valid", 64'(wb_valid), 64'd1);
    chk("R4 used=4 wb_idx", 64'(wb_idx), 64'd3);
    chk("R5 matched no count", 64'(eoi_count), 64'(c0));

    // R5: 32 unmatched EOIs bring the counter back around
    lr_used = 3'd0;
    c0 = eoi_count;
    for (int k = 0; k < 31; k++) do_eoi(16'd5, 1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h40);
    chk("R5 count before wrap", 64'(eoi_count), 64'(5'(c0 + 5'd31)));
    do_eoi(16'd5, 1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h40);
    chk("R5 count wraps", 64'(eoi_count), 64'(c0));
    chk("R5 no wb when unmatched", 64'(wb_valid), 64'd0);

    // R10: maintenance expectation
    ent[2][26] = 1'b1;
    ent[3][26] = 1'b1;
    load_bank();
    lr_live = 4'b0100; uie = 1'b0;
    #1 chk("R10 notify on hw entry", 64'(maint_expect), 64'd0);
    lr_live = 4'b1100;
    #1 chk("R10 notify on plain entry", 64'(maint_expect), 64'd1);
    lr_live = 4'b0011;
    #1 chk("R10 not live", 64'(maint_expect), 64'd0);
    uie = 1'b1;
    #1 chk("R10 underflow enable", 64'(maint_expect), 64'd1);

    // R11: reset clears the counter
    lr_used = 3'd0;
    do_eoi(16'd5, 1'b1, 1'b0, 3'd2, 3'd3, 1'b0, 8'h40);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R11 count cleared", 64'(eoi_count), 64'd0);
    chk("R11 wb cleared", 64'(wb_valid), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule